// File: doc/BRIEF.md
# Slow-Clock Phase Tracker with Slot Enables

This block sits in a fast clock domain that runs at four times a slow clock. Both clocks come from one source, so their edges coincide. The block works out which of the four fast cycles inside each slow period is current, and it turns that position into one-cycle enables. The slow domain holds a single flip-flop that inverts on every slow rising edge. The fast domain never looks at the slow clock itself, because that would be a setup/hold race. It samples the toggling flop instead and treats any change in the sampled value as proof that a slow edge happened one fast cycle earlier.

Each detected change loads a two-bit phase counter with 1. Between changes the counter counts up modulo 4. Phase 0 is therefore the fast cycle in which a change is detected, which is the second fast cycle after the slow rising edge. The block reports lock once two successive changes arrive exactly four fast cycles apart. Lock drops as soon as a change arrives at any other spacing. While locked, the block raises one enable per phase. It also splits the four-phase period into two halves, so that two slow-domain clients can take turns at a shared external SRAM.

Top module: `slot_phase_tracker`

## Requirements
- R1: While rst_n is low, locked, every bit of phase_en, grant_a and grant_b are 0.
- R2: A slow rising edge on the fast edge T makes phase read 1 after fast edge T+2. The toggling flop changes at T, the fast sampler sees the change at T+1, and the counter loads at T+2.
- R3: On a fast edge with no change detected, phase increases by 1 modulo 4.
- R4: When a change is detected exactly 4 fast cycles after the previous one, locked is 1 from the same edge that loads phase with 1.
- R5: A change detected 5, 6, 7, 8 or more fast cycles after the previous one clears locked at its load edge. A spacing of 8 must not look nominal even though the phase counter has wrapped.
- R6: The first change after reset loads phase but leaves locked at 0.
- R7: phase_en[k] is 1 exactly when locked is 1 and phase equals k. At most one bit is set, and all bits are 0 while unlocked.
- R8: grant_a is 1 when locked and phase is 0 or 1. grant_b is 1 when locked and phase is 2 or 3. Both are 0 while unlocked, and they are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock, 4x the slow clock and edge-aligned with it |
| clk_slow | input | 1 | Slow clock; drives only the toggling flop |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| phase | output | PH_W | Current phase within the slow period |
| locked | output | 1 | Phase has been confirmed by two changes at nominal spacing |
| phase_en | output | 2**PH_W | One-hot per-phase enable, gated by locked |
| grant_a | output | 1 | SRAM slot owned by client A (phases 0 and 1) |
| grant_b | output | 1 | SRAM slot owned by client B (phases 2 and 3) |

## Verification
Every result is due two fast edges after the slow rising edge. The first edge takes the slow flop's new value into the sampler. The second edge loads phase and updates locked together. phase_en and the grants are combinational from those registers, so they follow on the same edge. The bench samples at every falling edge of the fast clock. It timestamps each slow rising edge by the index of the fast edge it shares, lets the predicted load take effect at index T+2, and between loads advances phase by one per fast edge. The slow low time is stretched by 1, 2, 3, 4 and 8 fast cycles to produce the off-nominal spacings.

// File: rtl/phtrk_pkg.sv
package phtrk_pkg;
  // next phase value, modulo the number of phases
  function automatic int ph_step(input int p, input int nph);
    return (p + 1) % nph;
  endfunction

  // gap counter step, saturating at lim
  function automatic int gap_step(input int g, input int lim);
    return (g >= lim) ? lim : g + 1;
  endfunction

  // a change is nominal when it lands one full period after the last
  function automatic logic gap_nominal(input int g, input int nph);
    return g == nph - 1;
  endfunction
endpackage

// File: rtl/slow_toggle.sv
module slow_toggle (
  input  logic clk_slow,
  input  logic rst_n,
  output logic tog
);
  always_ff @(posedge clk_slow or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else        tog <= ~tog;
  end
endmodule

// File: rtl/toggle_edge.sv
module toggle_edge (
  input  logic clk_fast,
  input  logic rst_n,
  input  logic tog_in,
  output logic chg
);
  logic samp_q;
  logic prev_q;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= tog_in;
      prev_q <= samp_q;
    end
  end

  assign chg = samp_q ^ prev_q;

  // R2: the slow flop flips once per 4 fast cycles, so a change never repeats back to back
  chg_isolated_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    chg |=> !chg);
endmodule

// File: rtl/phase_track.sv
module phase_track #(
  parameter int PH_W = 2
) (
  input  logic            clk_fast,
  input  logic            rst_n,
  input  logic            chg,
  output logic [PH_W-1:0] phase,
  output logic            locked
);
  import phtrk_pkg::*;

  localparam int NPH   = 1 << PH_W;
  localparam int GAP_W = PH_W + 1;
  localparam int GAP_MAX = (1 << GAP_W) - 1;

  logic [PH_W-1:0]  ph_q;
  logic [GAP_W-1:0] gap_q;
  logic             lock_q;
  logic             gap_ok;

  assign gap_ok = gap_nominal(int'(gap_q), NPH);

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      gap_q  <= GAP_W'(GAP_MAX);
      lock_q <= 1'b0;
    end else if (chg) begin
      ph_q   <= PH_W'(1);
      gap_q  <= '0;
      lock_q <= gap_ok;
    end else begin
      ph_q   <= PH_W'(ph_step(int'(ph_q), NPH));
      gap_q  <= GAP_W'(gap_step(int'(gap_q), GAP_MAX));
    end
  end

  assign phase  = ph_q;
  assign locked = lock_q;

  // R2
  load_one_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    chg |=> phase == PH_W'(1));
  // R3
  phase_step_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !chg |=> (phase - $past(phase)) == PH_W'(1));
  // R4
  lock_cause_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $rose(locked) |-> $past(chg));
  // R5
  unlock_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (chg && !gap_ok) |=> !locked);
endmodule

// File: rtl/slot_phase_tracker.sv
module slot_phase_tracker #(
  parameter int PH_W = 2
) (
  input  logic                 clk_fast,
  input  logic                 clk_slow,
  input  logic                 rst_n,
  output logic [PH_W-1:0]      phase,
  output logic                 locked,
  output logic [(1<<PH_W)-1:0] phase_en,
  output logic                 grant_a,
  output logic                 grant_b
);
  localparam int NPH = 1 << PH_W;

  logic tog;
  logic chg;

  slow_toggle u_tog (
    .clk_slow (clk_slow),
    .rst_n    (rst_n),
    .tog      (tog)
  );

  toggle_edge u_edge (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .tog_in   (tog),
    .chg      (chg)
  );

  phase_track #(.PH_W(PH_W)) u_track (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .chg      (chg),
    .phase    (phase),
    .locked   (locked)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_en
    assign phase_en[k] = locked && (phase == PH_W'(k));
  end

  assign grant_a = locked & ~phase[PH_W-1];
  assign grant_b = locked &  phase[PH_W-1];

  // R7
  en_onehot_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $onehot0(phase_en));
  // R7
  en_quiet_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !locked |-> phase_en == '0);
  // R8
  grant_excl_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !(grant_a && grant_b));
  // R8
  grant_cover_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
    locked |-> (grant_a || grant_b));
endmodule

// File: tb/test_slot_phase_tracker.sv
`timescale 1ns/1ps
module test_slot_phase_tracker;
  logic clk_f = 1'b0;
  logic clk_s = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] phase;
  logic       locked;
  logic [3:0] phase_en;
  logic       grant_a, grant_b;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  slot_phase_tracker #(.PH_W(2)) i_slot_phase_tracker (
    .clk_fast (clk_f),
    .clk_slow (clk_s),
    .rst_n    (rst_n),
    .phase    (phase),
    .locked   (locked),
    .phase_en (phase_en),
    .grant_a  (grant_a),
    .grant_b  (grant_b)
  );

  // 125 MHz fast clock, posedges at 4, 12, 20, ...
  always #4 clk_f = ~clk_f;

  // slow clock: 4 fast periods, low time stretched on chosen cycles
  initial begin
    int k;
    k = 0;
    #4;
    forever begin
      #16 clk_s = 1'b1;
      #16 clk_s = 1'b0;
      k++;
      case (k)
        5:  #(8*1);
        12: #(8*4);
        18: #(8*2);
        25: #(8*3);
        31: #(8*8);
        default: ;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  // model state
  int  n = 0;
  bit  prev_s = 0;
  bit  pend_v = 0;
  int  pend_t = 0;
  bit  rlast_v = 0, rprev_v = 0;
  int  rlast = 0, rprev = 0;
  bit  lock_exp = 0;

  always @(negedge clk_f) begin
    if (!rst_n) begin
      // R1
      chk("R1", "locked", locked, 0);
      chk("R1", "phase_en", phase_en, 0);
      chk("R1", "grant_a", grant_a, 0);
      chk("R1", "grant_b", grant_b, 0);
    end else if (!done) begin
      n++;
      if (clk_s && !prev_s) begin
        pend_v = 1;
        pend_t = n;
      end
      if (pend_v && n == pend_t + 2) begin
        rprev_v = rlast_v;
        rprev   = rlast;
        rlast_v = 1;
        rlast   = pend_t;
        pend_v  = 0;
        lock_exp = rprev_v && (rlast - rprev == 4);
      end
      if (rlast_v && n >= rlast + 2) begin
        int pe;
        pe = (n - rlast - 1) % 4;
        if (n == rlast + 2) chk("R2", "phase after load", phase, pe);
        else                chk("R3", "phase count", phase, pe);
        if (!rprev_v)     chk("R6", "locked after first change", locked, lock_exp);
        else if (lock_exp) chk("R4", "locked at nominal spacing", locked, lock_exp);
        else              chk("R5", "locked at off spacing", locked, lock_exp);
        chk("R7", "phase_en", phase_en, lock_exp ? (1 << pe) : 0);
        chk("R8", "grant_a", grant_a, (lock_exp && pe < 2) ? 1 : 0);
        chk("R8", "grant_b", grant_b, (lock_exp && pe >= 2) ? 1 : 0);
      end else begin
        chk("R6", "locked before first load", locked, 0);
        chk("R7", "phase_en before lock", phase_en, 0);
      end
    end
    prev_s = clk_s;
  end

  initial begin
    #10 rst_n = 1'b1;
    repeat (260) @(negedge clk_f);
    #1;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule